// File: doc/BRIEF.md
# Mode-Gated Basic Control Register

This block holds the 8-bit basic-mode control word of a voice-processing device. A host writes and reads it over a simple one-cycle port. The block combines the stored bits with external pins to produce the internal control and status signals: power-down, coefficient clear and reset, line-codec power-down, clock-output enable, and the per-port enables of the serial PCM ports. The block does not contain the cancelling datapath, the codecs or the clock generator. It only drives the signals that go to them.

The block also tracks the device mode, which is one of power-down, initial or run. Configuration bits may change only while the device is not in run mode. A coefficient-reset request takes effect only on a rising edge of the frame sync. A disabled receive path is replaced by an all-ones idle sample, and its matching output enable is dropped.

Top module: `bmode_ctl_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the control word becomes 0x00, `mode_state` becomes 0 (power-down) and `coef_rst` becomes 0.
- R2: While `hw_pdn_n` is low, every control bit reads 0 after each edge and host writes are ignored.
- R3: The effective power-down is bit 7 OR NOT `hw_pdn_n`. Bit 7 = 1 means a power-down request. Whenever the effective power-down is active at an edge, `mode_state` becomes 0. In the first edge after it ends, mode 0 goes to mode 1 (initial).
- R4: At the edge where the device enters power-down from mode 1 or mode 2, bits 6..0 are cleared and bit 7 keeps its value. A host write in that same cycle is ignored. `coef_clr` is high for exactly the one cycle that follows that edge.
- R5: In mode 1, once bit 1 (operate) reads 1 and there is no power-down, the next edge moves `mode_state` to 2 (run).
- R6: In mode 2, host writes to bits 5..1 are ignored. Writes to bits 7 and 6 still take effect.
- R7: `coef_rst` is loaded with (bit 6 OR NOT `hw_crst_n`) only at edges where `frame_sync` has just risen. At all other edges it holds its value. `audio_mute` is `coef_rst` OR the effective power-down.
- R8: `codec_pd` is bit 5 OR `codec_pd_pin` OR the effective power-down. When `codec_pd` is high, `codec_out_oe` is 0 and `codec_rx` is all ones. Otherwise `codec_out_oe` is 1 and `codec_rx` equals `codec_in`.
- R9: `clk_out_oe` is 1 only when `clk_sel` is 0 (internal clock mode) and bit 4 is 0.
- R10: Bit 3 = 1 turns off the line PCM port: `pcm_line_oe` is 0 and `pcm_line_rx` is all ones. Bit 2 does the same for the auxiliary port (`pcm_aux_oe`, `pcm_aux_rx`). When a port is on, its receive output passes its input through.
- R11: Bit 0 is reserved. It always reads 0, whatever value was written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_pdn_n | input | 1 | Active-low power-down pin |
| hw_crst_n | input | 1 | Active-low coefficient-reset pin |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Current control word |
| frame_sync | input | 1 | Frame sync, sampled in the clock domain |
| codec_pd_pin | input | 1 | Line-codec power-down pin (active high) |
| clk_sel | input | 1 | Clock select, 0 = internal clock |
| codec_in | input | SAMPLE_W | Line-codec receive sample |
| pcm_line_in | input | SAMPLE_W | Line PCM receive sample |
| pcm_aux_in | input | SAMPLE_W | Auxiliary PCM receive sample |
| mode_state | output | 2 | 0 power-down, 1 initial, 2 run |
| pdn_active | output | 1 | Mode is power-down |
| coef_clr | output | 1 | One-cycle coefficient clear on power-down entry |
| coef_rst | output | 1 | Frame-synchronised coefficient reset |
| audio_mute | output | 1 | Audio outputs muted |
| codec_pd | output | 1 | Line codec powered down |
| codec_out_oe | output | 1 | Line-codec output enable |
| codec_rx | output | SAMPLE_W | Gated codec sample |
| clk_out_oe | output | 1 | Sync/bit-clock output enable |
| pcm_line_oe | output | 1 | Line PCM output enable |
| pcm_aux_oe | output | 1 | Auxiliary PCM output enable |
| pcm_line_rx | output | SAMPLE_W | Gated line PCM sample |
| pcm_aux_rx | output | SAMPLE_W | Gated auxiliary PCM sample |

## Verification
The bench builds the block with the default SAMPLE_W of 8. With that width the idle pattern is 8'hFF, which makes it easy to tell apart from the fixed test samples. In initial mode the bench sweeps all sixteen combinations of the four configuration bits against both clock-select values and both codec pin values, so every enable and substitution term is checked. It then repeats the sixteen-pattern write sweep in run mode to show the lock. After that it walks the mode sequence through soft and pin-driven power-down, and steps the frame sync through rising, held and falling cycles to show when the reset request is captured.

// File: rtl/bmode_pkg.sv
package bmode_pkg;

    localparam int CTRL_W = 8;

    // Writable in any mode: power-down request and coefficient reset request
    localparam logic [CTRL_W-1:0] FREE_MASK = 8'b1100_0000;
    // Writable only outside run mode: codec/clock/port configuration and operate
    localparam logic [CTRL_W-1:0] CFG_MASK  = 8'b0011_1110;

    typedef enum logic [1:0] {
        MODE_PDN  = 2'd0,
        MODE_INIT = 2'd1,
        MODE_RUN  = 2'd2
    } mode_e;

    typedef struct packed {
        logic pdn;        // bit 7
        logic crst;       // bit 6
        logic codec_off;  // bit 5
        logic clk_off;    // bit 4
        logic line_off;   // bit 3
        logic aux_off;    // bit 2
        logic oper;       // bit 1
        logic rsvd;       // bit 0, always 0
    } ctrl_t;

    function automatic ctrl_t merge_write(ctrl_t cur, logic [CTRL_W-1:0] wd,
                                          logic cfg_open);
        logic [CTRL_W-1:0] mask;
        mask = FREE_MASK | (cfg_open ? CFG_MASK : '0);
        return ctrl_t'((cur & ~mask) | (wd & mask));
    endfunction

endpackage

// File: rtl/bmode_regfile.sv
module bmode_regfile
    import bmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_pd,
    input  logic              host_we,
    input  logic [CTRL_W-1:0] host_wdata,
    output ctrl_t             ctrl_q,
    output mode_e             mode_q,
    output logic              pd_eff,
    output logic              clr_pulse
);

    logic entry;
    logic cfg_open;

    always_comb begin
        pd_eff   = ctrl_q.pdn | pin_pd;
        entry    = pd_eff && (mode_q != MODE_PDN);
        cfg_open = (mode_q != MODE_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            mode_q    <= MODE_PDN;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= entry;

            if (pin_pd) begin
                ctrl_q <= '0;
            end else if (entry) begin
                ctrl_q      <= '0;
                ctrl_q.pdn  <= ctrl_q.pdn;
            end else if (host_we) begin
                ctrl_q <= merge_write(ctrl_q, host_wdata, cfg_open);
            end

            if (pd_eff) begin
                mode_q <= MODE_PDN;
            end else begin
                case (mode_q)
                    MODE_PDN:  mode_q <= MODE_INIT;
                    MODE_INIT: if (ctrl_q.oper) mode_q <= MODE_RUN;
                    MODE_RUN:  mode_q <= MODE_RUN;
                    default:   mode_q <= MODE_PDN;
                endcase
            end
        end
    end

endmodule

// File: rtl/bmode_crst_sampler.sv
module bmode_crst_sampler (
    input  logic clk,
    input  logic rst,
    input  logic frame_sync,
    input  logic req,
    output logic coef_rst
);

    logic fs_prev;
    logic fs_rise;

    assign fs_rise = frame_sync & ~fs_prev;

    always_ff @(posedge clk) begin
        fs_prev <= frame_sync;
    end

    always_ff @(posedge clk) begin
        if (rst)          coef_rst <= 1'b0;
        else if (fs_rise) coef_rst <= req;
    end

endmodule

// File: rtl/bmode_port_gate.sv
module bmode_port_gate #(
    parameter int W = 8
) (
    input  logic         off,
    input  logic [W-1:0] din,
    output logic         oe,
    output logic [W-1:0] dout
);

    localparam logic [W-1:0] IDLE = {W{1'b1}};

    always_comb begin
        oe   = ~off;
        dout = off ? IDLE : din;
    end

endmodule

// File: rtl/bmode_ctl_reg.sv
module bmode_ctl_reg
    import bmode_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_pdn_n,
    input  logic                hw_crst_n,
    input  logic                host_we,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          host_rdata,
    input  logic                frame_sync,
    input  logic                codec_pd_pin,
    input  logic                clk_sel,
    input  logic [SAMPLE_W-1:0] codec_in,
    input  logic [SAMPLE_W-1:0] pcm_line_in,
    input  logic [SAMPLE_W-1:0] pcm_aux_in,
    output logic [1:0]          mode_state,
    output logic                pdn_active,
    output logic                coef_clr,
    output logic                coef_rst,
    output logic                audio_mute,
    output logic                codec_pd,
    output logic                codec_out_oe,
    output logic [SAMPLE_W-1:0] codec_rx,
    output logic                clk_out_oe,
    output logic                pcm_line_oe,
    output logic                pcm_aux_oe,
    output logic [SAMPLE_W-1:0] pcm_line_rx,
    output logic [SAMPLE_W-1:0] pcm_aux_rx
);

    localparam int NUM_PCM = 2;

    ctrl_t ctrl_q;
    mode_e mode_q;
    logic  pd_eff;

    bmode_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .pin_pd     (~hw_pdn_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .ctrl_q     (ctrl_q),
        .mode_q     (mode_q),
        .pd_eff     (pd_eff),
        .clr_pulse  (coef_clr)
    );

    bmode_crst_sampler u_crst (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .req        (ctrl_q.crst | ~hw_crst_n),
        .coef_rst   (coef_rst)
    );

    always_comb begin
        host_rdata = ctrl_q;
        mode_state = mode_q;
        pdn_active = (mode_q == MODE_PDN);
        audio_mute = coef_rst | pd_eff;
        codec_pd   = ctrl_q.codec_off | codec_pd_pin | pd_eff;
        clk_out_oe = ~clk_sel & ~ctrl_q.clk_off;
    end

    bmode_port_gate #(.W(SAMPLE_W)) u_codec_gate (
        .off  (codec_pd),
        .din  (codec_in),
        .oe   (codec_out_oe),
        .dout (codec_rx)
    );

    logic [NUM_PCM-1:0]  pcm_off;
    logic [NUM_PCM-1:0]  pcm_oe;
    logic [SAMPLE_W-1:0] pcm_din  [NUM_PCM];
    logic [SAMPLE_W-1:0] pcm_dout [NUM_PCM];

    assign pcm_off    = {ctrl_q.aux_off, ctrl_q.line_off};
    assign pcm_din[0] = pcm_line_in;
    assign pcm_din[1] = pcm_aux_in;

    generate
        for (genvar p = 0; p < NUM_PCM; p++) begin : g_pcm
            bmode_port_gate #(.W(SAMPLE_W)) u_gate (
                .off  (pcm_off[p]),
                .din  (pcm_din[p]),
                .oe   (pcm_oe[p]),
                .dout (pcm_dout[p])
            );
        end
    endgenerate

    assign pcm_line_oe = pcm_oe[0];
    assign pcm_aux_oe  = pcm_oe[1];
    assign pcm_line_rx = pcm_dout[0];
    assign pcm_aux_rx  = pcm_dout[1];

endmodule

// File: rtl/bmode_chk.sv
module bmode_chk #(
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                hw_pdn_n,
    input logic                frame_sync,
    input logic                clk_sel,
    input logic [7:0]          host_rdata,
    input logic [1:0]          mode_state,
    input logic                coef_clr,
    input logic                coef_rst,
    input logic                codec_out_oe,
    input logic [SAMPLE_W-1:0] codec_rx,
    input logic                clk_out_oe
);

    assert_pin_clears_R2: assert property (@(posedge clk) disable iff (rst)
        !hw_pdn_n |=> host_rdata == 8'h00);

    assert_pdn_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (host_rdata[7] || !hw_pdn_n) |=> mode_state == 2'd0);

    assert_clr_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        coef_clr |=> !coef_clr);

    assert_to_run_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd1 && host_rdata[1] && !host_rdata[7] && hw_pdn_n)
        |=> mode_state == 2'd2);

    assert_run_lock_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_state == 2'd2 && !host_rdata[7] && hw_pdn_n)
        |=> $stable(host_rdata[5:1]));

    assert_crst_edge_only_R7: assert property (@(posedge clk) disable iff (rst)
        !$rose(frame_sync) |=> $stable(coef_rst));

    assert_pin_codec_off_R8: assert property (@(posedge clk) disable iff (rst)
        !hw_pdn_n |-> (!codec_out_oe && codec_rx == {SAMPLE_W{1'b1}}));

    assert_ext_clk_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
        clk_sel |-> !clk_out_oe);

    assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> host_rdata[0] == 1'b0);

endmodule

bind bmode_ctl_reg bmode_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hw_pdn_n     (hw_pdn_n),
    .frame_sync   (frame_sync),
    .clk_sel      (clk_sel),
    .host_rdata   (host_rdata),
    .mode_state   (mode_state),
    .coef_clr     (coef_clr),
    .coef_rst     (coef_rst),
    .codec_out_oe (codec_out_oe),
    .codec_rx     (codec_rx),
    .clk_out_oe   (clk_out_oe)
);

// File: tb/sim_bmode_ctl_reg.sv
`timescale 1ns/1ps
module sim_bmode_ctl_reg;

    localparam int W = 8;
    localparam logic [W-1:0] IDLE = {W{1'b1}};
    localparam logic [W-1:0] S_CODEC = 8'h5A;
    localparam logic [W-1:0] S_LINE  = 8'h3C;
    localparam logic [W-1:0] S_AUX   = 8'hC3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hw_pdn_n = 1'b1, hw_crst_n = 1'b1;
    logic host_we = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic frame_sync = 1'b0, codec_pd_pin = 1'b0, clk_sel = 1'b0;
    logic [W-1:0] codec_in = S_CODEC, pcm_line_in = S_LINE, pcm_aux_in = S_AUX;

    logic [7:0] host_rdata;
    logic [1:0] mode_state;
    logic pdn_active, coef_clr, coef_rst, audio_mute, codec_pd, codec_out_oe;
    logic clk_out_oe, pcm_line_oe, pcm_aux_oe;
    logic [W-1:0] codec_rx, pcm_line_rx, pcm_aux_rx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bmode_ctl_reg #(.SAMPLE_W(W)) u0 (
        .clk(clk), .rst(rst), .hw_pdn_n(hw_pdn_n), .hw_crst_n(hw_crst_n),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .frame_sync(frame_sync), .codec_pd_pin(codec_pd_pin), .clk_sel(clk_sel),
        .codec_in(codec_in), .pcm_line_in(pcm_line_in), .pcm_aux_in(pcm_aux_in),
        .mode_state(mode_state), .pdn_active(pdn_active), .coef_clr(coef_clr),
        .coef_rst(coef_rst), .audio_mute(audio_mute), .codec_pd(codec_pd),
        .codec_out_oe(codec_out_oe), .codec_rx(codec_rx), .clk_out_oe(clk_out_oe),
        .pcm_line_oe(pcm_line_oe), .pcm_aux_oe(pcm_aux_oe),
        .pcm_line_rx(pcm_line_rx), .pcm_aux_rx(pcm_aux_rx)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: returns 1 ns after the rising edge, inputs are driven there
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic host_write(logic [7:0] v);
        host_we = 1'b1;
        host_wdata = v;
        tick();
        host_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        check("R1 reset word", host_rdata, 8'h00);
        check("R1 reset mode", mode_state, 2'd0);
        check("R1 reset coef_rst", coef_rst, 1'b0);
        rst = 1'b0;
        tick();
        check("R3 release to initial", mode_state, 2'd1);

        // Configuration sweep in initial mode (R8, R9, R10, R11)
        for (int c = 0; c < 16; c++) begin
            for (int ks = 0; ks < 2; ks++) begin
                for (int cp = 0; cp < 2; cp++) begin
                    logic [7:0] exp_word;
                    logic cpd, loff, aoff;
                    exp_word = {2'b00, c[3:0], 2'b00};
                    host_write(exp_word | 8'h01);
                    clk_sel = ks[0];
                    codec_pd_pin = cp[0];
                    #1;
                    check("R11 reserved bit", host_rdata, exp_word);
                    check("R5 stays initial", mode_state, 2'd1);
                    cpd  = c[3] | cp[0];
                    loff = c[1];
                    aoff = c[0];
                    check("R8 codec_pd", codec_pd, cpd);
                    check("R8 codec oe", codec_out_oe, !cpd);
                    check("R8 codec rx", codec_rx, cpd ? IDLE : S_CODEC);
                    check("R9 clk oe", clk_out_oe, !ks[0] && !c[2]);
                    check("R10 line oe", pcm_line_oe, !loff);
                    check("R10 line rx", pcm_line_rx, loff ? IDLE : S_LINE);
                    check("R10 aux oe", pcm_aux_oe, !aoff);
                    check("R10 aux rx", pcm_aux_rx, aoff ? IDLE : S_AUX);
                end
            end
        end
        clk_sel = 1'b0;
        codec_pd_pin = 1'b0;

        // Operate bit (R5)
        host_write(8'h16);
        check("R5 operate read", host_rdata, 8'h16);
        check("R5 one edge later still initial", mode_state, 2'd1);
        tick();
        check("R5 run", mode_state, 2'd2);

        // Lock in run mode (R6)
        for (int c = 0; c < 16; c++) begin
            host_write({2'b00, c[3:0], 2'b00});
            check("R6 cfg locked", host_rdata, 8'h16);
            check("R6 mode held", mode_state, 2'd2);
        end
        host_write(8'h40);
        check("R6 bit6 free in run", host_rdata, 8'h56);

        // Frame-synchronous coefficient reset (R7)
        check("R7 no capture yet", coef_rst, 1'b0);
        check("R7 mute off", audio_mute, 1'b0);
        frame_sync = 1'b1;
        tick();
        check("R7 captured on rise", coef_rst, 1'b1);
        check("R7 mute on", audio_mute, 1'b1);
        host_write(8'h00);
        check("R7 bit6 cleared", host_rdata, 8'h16);
        check("R7 held while sync high", coef_rst, 1'b1);
        frame_sync = 1'b0;
        tick();
        check("R7 held on fall", coef_rst, 1'b1);
        frame_sync = 1'b1;
        tick();
        check("R7 released on rise", coef_rst, 1'b0);
        hw_crst_n = 1'b0;
        tick();
        check("R7 pin ignored without edge", coef_rst, 1'b0);
        frame_sync = 1'b0;
        tick();
        frame_sync = 1'b1;
        tick();
        check("R7 pin captured", coef_rst, 1'b1);
        hw_crst_n = 1'b1;
        frame_sync = 1'b0;
        tick();
        frame_sync = 1'b1;
        tick();
        check("R7 pin release", coef_rst, 1'b0);

        // Soft power-down (R3, R4)
        host_write(8'h80);
        check("R4 request read", host_rdata, 8'h96);
        check("R4 mode before entry", mode_state, 2'd2);
        check("R8 codec off in power-down", codec_out_oe, 1'b0);
        check("R7 mute in power-down", audio_mute, 1'b1);
        tick();
        check("R4 cleared except bit7", host_rdata, 8'h80);
        check("R3 soft pd mode", mode_state, 2'd0);
        check("R3 pdn_active", pdn_active, 1'b1);
        check("R4 clear pulse", coef_clr, 1'b1);
        tick();
        check("R4 pulse one cycle", coef_clr, 1'b0);
        host_write(8'hA8);
        check("R3 cfg open in pd", host_rdata, 8'hA8);
        host_write(8'h28);
        check("R3 release read", host_rdata, 8'h28);
        check("R3 still pd at release edge", mode_state, 2'd0);
        tick();
        check("R3 initial after release", mode_state, 2'd1);

        // Pin power-down (R2)
        hw_pdn_n = 1'b0;
        #1;
        check("R8 pin codec off", codec_out_oe, 1'b0);
        tick();
        check("R2 pin clears", host_rdata, 8'h00);
        check("R3 pin pd mode", mode_state, 2'd0);
        check("R4 pin clear pulse", coef_clr, 1'b1);
        host_write(8'h3C);
        check("R2 write ignored", host_rdata, 8'h00);
        check("R4 no pulse while in pd", coef_clr, 1'b0);
        hw_pdn_n = 1'b1;
        tick();
        check("R3 pin release initial", mode_state, 2'd1);
        check("R2 word after release", host_rdata, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule